// File: doc/BRIEF.md
# DMA Channel Run-Control Register

This block holds the run-control and status word of one DMA channel and sits between a simple register port and the command engine that walks the descriptor list. Software changes channel state with a single 32-bit write. The upper half of the word is a per-bit enable mask and the lower half carries the new values, so any subset of flags can change without a read-modify-write. The engine sees level requests for run, pause and flush, and a one-cycle wake pulse. It reports back whether it is busy, whether it has hit a fatal error, and whether its last branch was taken.

The status word reads back on a 32-bit port. The flags sit in the upper byte of its low half and a software-owned eight-bit device field sits in the low byte. Some flags belong to the engine: software may clear them but can never set them. Flush clears itself once the engine confirms that partial data has been written out.

Top module: `chan_runctl`

## Requirements
- R1: A synchronous active-high reset clears the whole status word and every request output to the engine. Afterwards, rd_data reads 0 and run, pause, flush and wake are all low.
- R2: A write to the control word with enable bit n+16 set loads bit n of the write into status bit n. This applies to RUN (bit 15), PAUSE (bit 14) and the device field (bits 7:0). A bit whose enable is clear keeps its value, and nothing changes in a cycle without a write.
- R3: Status layout: RUN 15, PAUSE 14, FLUSH 13, WAKE 12, DEAD 11, ACTIVE 10, branch-taken 8, device field 7:0. Bits 31:16 and bit 9 always read 0, and writes aimed at bit 9 have no effect.
- R4: Writing FLUSH with value 1 sets it. It then stays set until the cycle after flush_done_i is high, when it clears. Writing FLUSH with enable set and value 0 also clears it.
- R5: Writing WAKE with value 1 raises wake_o and status bit 12 for exactly one cycle. Both return to 0 on the next cycle without another write.
- R6: DEAD is set in the cycle after eng_dead_i is high and then stays set. A software write of 1 to it has no effect. A software write of 0 clears it, but engine assertion in the same cycle wins.
- R7: ACTIVE is set in the cycle after eng_active_i rises. It clears after eng_active_i falls, or after a software write of 0 to it. A software write of 1 to it has no effect.
- R8: Branch-taken (bit 8) shows eng_branch_i delayed by one cycle. Software writes to bit 8 are ignored.
- R9: A stop write (0xA000_0000: enables for RUN and FLUSH, values 0) clears RUN and FLUSH on the next cycle. ACTIVE then reads 0 once the engine drops eng_active_i.
- R10: A reset write (0xFC00_0000: enables for RUN, PAUSE, FLUSH, WAKE, DEAD and ACTIVE, values 0) leaves RUN reading 0, together with the other five flags. The device field is not touched.
- R11: run_o, pause_o, flush_o and wake_o always equal status bits 15, 14, 13 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 32 | Control word: enable mask 31:16, values 15:0 |
| rd_data | output | 32 | Status word |
| run_o | output | 1 | Run request to the engine |
| pause_o | output | 1 | Pause request to the engine |
| flush_o | output | 1 | Flush request to the engine |
| wake_o | output | 1 | One-cycle wake pulse to the engine |
| eng_active_i | input | 1 | Engine is processing descriptors |
| eng_dead_i | input | 1 | Engine fatal error |
| eng_branch_i | input | 1 | Engine took its last branch |
| flush_done_i | input | 1 | Engine finished writing out partial data |

## Verification
The hardest case to reach from the ports is a software clear of an engine-owned flag that lands in the same cycle as an engine event. Examples are clearing DEAD while eng_dead_i is still high, or clearing ACTIVE while eng_active_i stays high with no new rising edge. The stimulus table walks the channel through a fixed history in which these overlaps happen on chosen rows, and checks the full status word after each edge. A later stop sequence, a reset write and a mid-run hardware reset are driven as directed tests.

// File: rtl/runctl_pkg.sv
package runctl_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int DEV_W  = 8;

    // Status bit positions; software and engine both depend on them
    localparam int B_RUN   = 15;
    localparam int B_PAUSE = 14;
    localparam int B_FLUSH = 13;
    localparam int B_WAKE  = 12;
    localparam int B_DEAD  = 11;
    localparam int B_ACT   = 10;
    localparam int B_BT    = 8;

    typedef struct packed {
        logic             run;
        logic             pause;
        logic             flush;
        logic             wake;
        logic             dead;
        logic             active;
        logic             rsvd;
        logic             btaken;
        logic [DEV_W-1:0] dev;
    } stat_t;

    typedef struct packed {
        logic [HALF_W-1:0] en;
        logic [HALF_W-1:0] val;
    } ctl_t;

    // Selective clear/set requests for a single bit
    function automatic logic bit_clr(input ctl_t c, input int b);
        return c.en[b] & ~c.val[b];
    endfunction

    function automatic logic bit_set(input ctl_t c, input int b);
        return c.en[b] & c.val[b];
    endfunction
endpackage

// File: rtl/runctl_mreg.sv
module runctl_mreg #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] en,
    input  logic [W-1:0] val,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~en) | (val & en);
    end

    // R2
    masked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |=> $stable(q));
endmodule

// File: rtl/runctl_eflags.sv
module runctl_eflags
    import runctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  ctl_t ctl,
    input  logic eng_active_i,
    input  logic eng_dead_i,
    input  logic eng_branch_i,
    input  logic flush_done_i,
    output logic flush_q,
    output logic wake_q,
    output logic dead_q,
    output logic active_q,
    output logic bt_q
);
    logic act_prev;
    logic act_rise, act_fall;
    logic fl_set, fl_clr, wk_set, dd_clr, ac_clr;

    assign act_rise = eng_active_i & ~act_prev;
    assign act_fall = ~eng_active_i & act_prev;
    assign fl_set   = wr_en & bit_set(ctl, B_FLUSH);
    assign fl_clr   = wr_en & bit_clr(ctl, B_FLUSH);
    assign wk_set   = wr_en & bit_set(ctl, B_WAKE);
    assign dd_clr   = wr_en & bit_clr(ctl, B_DEAD);
    assign ac_clr   = wr_en & bit_clr(ctl, B_ACT);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_prev <= 1'b0;
            flush_q  <= 1'b0;
            wake_q   <= 1'b0;
            dead_q   <= 1'b0;
            active_q <= 1'b0;
            bt_q     <= 1'b0;
        end else begin
            act_prev <= eng_active_i;
            if (fl_set)                     flush_q <= 1'b1;
            else if (fl_clr || flush_done_i) flush_q <= 1'b0;
            wake_q   <= wk_set;
            dead_q   <= eng_dead_i | (dead_q & ~dd_clr);
            active_q <= act_rise | (active_q & ~act_fall & ~ac_clr);
            bt_q     <= eng_branch_i;
        end
    end

    // R4
    flush_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flush_q && !flush_done_i && !fl_clr) |=> flush_q);
    // R5
    wake_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_q && !wk_set) |=> !wake_q);
    // R6
    dead_nosw_chk: assert property (@(posedge clk) disable iff (rst)
        (!dead_q && !eng_dead_i) |=> !dead_q);
    // R7
    active_nosw_chk: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !act_rise) |=> !active_q);
endmodule

// File: rtl/chan_runctl.sv
module chan_runctl
    import runctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              run_o,
    output logic              pause_o,
    output logic              flush_o,
    output logic              wake_o,
    input  logic              eng_active_i,
    input  logic              eng_dead_i,
    input  logic              eng_branch_i,
    input  logic              flush_done_i
);
    ctl_t  ctl;
    stat_t st;
    logic [1:0]       rp_q;
    logic [DEV_W-1:0] dev_q;
    logic flush_q, wake_q, dead_q, active_q, bt_q;
    logic unused_bits;

    assign ctl = ctl_t'(wr_data);
    assign unused_bits = ^{ctl.en[9:8], ctl.val[9:8]};

    runctl_mreg #(.W(2)) u_runpause (
        .clk (clk),
        .rst (rst),
        .en  ({2{wr_en}} & ctl.en[B_RUN:B_PAUSE]),
        .val (ctl.val[B_RUN:B_PAUSE]),
        .q   (rp_q)
    );

    runctl_mreg #(.W(DEV_W)) u_dev (
        .clk (clk),
        .rst (rst),
        .en  ({DEV_W{wr_en}} & ctl.en[DEV_W-1:0]),
        .val (ctl.val[DEV_W-1:0]),
        .q   (dev_q)
    );

    runctl_eflags u_flags (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .ctl          (ctl),
        .eng_active_i (eng_active_i),
        .eng_dead_i   (eng_dead_i),
        .eng_branch_i (eng_branch_i),
        .flush_done_i (flush_done_i),
        .flush_q      (flush_q),
        .wake_q       (wake_q),
        .dead_q       (dead_q),
        .active_q     (active_q),
        .bt_q         (bt_q)
    );

    always_comb begin
        st        = '0;
        st.run    = rp_q[1];
        st.pause  = rp_q[0];
        st.flush  = flush_q;
        st.wake   = wake_q;
        st.dead   = dead_q;
        st.active = active_q;
        st.btaken = bt_q;
        st.dev    = dev_q;
    end

    assign rd_data = {{(WORD_W-HALF_W){1'b0}}, st};
    assign run_o   = rp_q[1];
    assign pause_o = rp_q[0];
    assign flush_o = flush_q;
    assign wake_o  = wake_q;

    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data[WORD_W-1:HALF_W] == '0) && !rd_data[9]);
    // R9
    stop_run_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data == 32'hA000_0000) |=> (!run_o && !flush_o));
    // R10
    rstwr_run_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data == 32'hFC00_0000) |=> !rd_data[15]);
endmodule

// File: tb/chan_runctl_test.sv
module chan_runctl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        run_o, pause_o, flush_o, wake_o;
    logic        eng_active_i, eng_dead_i, eng_branch_i, flush_done_i;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;  // 50 MHz

    chan_runctl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .run_o(run_o), .pause_o(pause_o), .flush_o(flush_o), .wake_o(wake_o),
        .eng_active_i(eng_active_i), .eng_dead_i(eng_dead_i),
        .eng_branch_i(eng_branch_i), .flush_done_i(flush_done_i)
    );

    // Row: write strobe, control word, engine {active,dead,branch,done},
    // expected status after the edge, requirement number for messages.
    typedef struct packed {
        logic        wr;
        logic [31:0] data;
        logic [3:0]  eng;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VT [NV] = '{
        '{1'b1, 32'h8000_8000, 4'b0000, 16'h8000, 8'd2},  // R2 set run
        '{1'b1, 32'hC0FF_40A5, 4'b0000, 16'h40A5, 8'd2},  // R2 run off, pause on, dev A5
        '{1'b1, 32'h00F0_00FF, 4'b0000, 16'h40F5, 8'd2},  // R2 upper nibble only
        '{1'b1, 32'h0200_0200, 4'b0000, 16'h40F5, 8'd3},  // R3 bit 9 ignored
        '{1'b1, 32'h0100_0100, 4'b0000, 16'h40F5, 8'd8},  // R8 sw write ignored
        '{1'b0, 32'h0,         4'b0010, 16'h41F5, 8'd8},  // R8 branch follows
        '{1'b0, 32'h0,         4'b0000, 16'h40F5, 8'd8},
        '{1'b1, 32'h2000_2000, 4'b0000, 16'h60F5, 8'd4},  // R4 flush set
        '{1'b0, 32'h0,         4'b0000, 16'h60F5, 8'd4},  // R4 holds
        '{1'b0, 32'h0,         4'b0001, 16'h40F5, 8'd4},  // R4 cleared by ack
        '{1'b1, 32'h1000_1000, 4'b0000, 16'h50F5, 8'd5},  // R5 wake
        '{1'b0, 32'h0,         4'b0000, 16'h40F5, 8'd5},  // R5 self-clear
        '{1'b0, 32'h0,         4'b1000, 16'h44F5, 8'd7},  // R7 rise
        '{1'b1, 32'h0400_0000, 4'b1000, 16'h40F5, 8'd7},  // R7 sw clear
        '{1'b0, 32'h0,         4'b1000, 16'h40F5, 8'd7},  // R7 no new rise
        '{1'b0, 32'h0,         4'b0000, 16'h40F5, 8'd7},
        '{1'b1, 32'h0400_0400, 4'b0000, 16'h40F5, 8'd7},  // R7 sw set ignored
        '{1'b0, 32'h0,         4'b0100, 16'h48F5, 8'd6},  // R6 dead
        '{1'b1, 32'h0800_0800, 4'b0000, 16'h48F5, 8'd6},  // R6 sticky
        '{1'b1, 32'h0800_0000, 4'b0000, 16'h40F5, 8'd6},  // R6 sw clear
        '{1'b1, 32'h0800_0000, 4'b0100, 16'h48F5, 8'd6},  // R6 engine wins
        '{1'b1, 32'h0800_0000, 4'b0000, 16'h40F5, 8'd6},
        '{1'b1, 32'h8000_8000, 4'b1000, 16'hC4F5, 8'd7},  // R7 run + active
        '{1'b1, 32'h2000_2000, 4'b1000, 16'hE4F5, 8'd4},
        '{1'b1, 32'hA000_0000, 4'b1000, 16'h44F5, 8'd9},  // R9 stop
        '{1'b0, 32'h0,         4'b0000, 16'h40F5, 8'd9},  // R9 drained
        '{1'b1, 32'h9000_9000, 4'b0000, 16'hD0F5, 8'd5},
        '{1'b1, 32'hFC00_0000, 4'b0000, 16'h00F5, 8'd10}  // R10 reset write
    };

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [31:0] d, input logic [3:0] e);
        wr_en = w; wr_data = d;
        {eng_active_i, eng_dead_i, eng_branch_i, flush_done_i} = e;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 32'h0, 4'b0000);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check32("R1", rd_data, 32'h0);
        check32("R1", {28'h0, run_o, pause_o, flush_o, wake_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VT[i].wr, VT[i].data, VT[i].eng);
            @(negedge clk);
            check32($sformatf("R%0d row %0d", VT[i].req, i), rd_data, {16'h0, VT[i].exp});
            // R11 request outputs equal status bits 15:12
            check32("R11", {28'h0, run_o, pause_o, flush_o, wake_o},
                    {28'h0, VT[i].exp[15:12]});
        end
        drive(1'b0, 32'h0, 4'b0000);
        @(negedge clk);

        // R4 software clear of a pending flush
        drive(1'b1, 32'h2000_2000, 4'b0000); @(negedge clk);
        drive(1'b1, 32'h2000_0000, 4'b0000); @(negedge clk);
        check32("R4 sw clear", rd_data, 32'h0000_00F5);

        // R3 writes to every upper bit and bit 9 leave reserved bits zero
        drive(1'b1, 32'hFFFF_FFFF, 4'b0000); @(negedge clk);
        check32("R3 all ones", rd_data, 32'h0000_F0FF);
        drive(1'b0, 32'h0, 4'b0000); @(negedge clk);
        check32("R5 wake drops", rd_data, 32'h0000_E0FF);

        // R1 hardware reset mid-run
        drive(1'b0, 32'h0, 4'b1110);
        @(negedge clk);
        rst = 1'b1; @(negedge clk);
        drive(1'b0, 32'h0, 4'b0000);
        rst = 1'b0;
        check32("R1 mid-run", rd_data, 32'h0);
        check32("R1 outputs", {28'h0, run_o, pause_o, flush_o, wake_o}, 32'h0);

        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule